// File: doc/BRIEF.md
# Paced Source-Fetch Request Controller

This block paces the read requests that pull one frame of source data from a system bus into a small ring of input FIFO slots. A frame begins with a one-cycle start pulse that carries the frame's base address, its length in blocks, the pacing interval and the largest payload, in blocks, that one bus read may carry. One slot holds one block. Each time the pacing timer runs out, the controller sizes a request. The size is the smallest of three values: the blocks still to fetch, the payload cap, and the number of slots that are not allocated. A request of size zero is never issued.

A slot table keeps three ring pointers. The allocation pointer moves forward by the size of each request. The landing pointer moves forward on every bus data beat that returns a block. The drain pointer moves forward when a downstream consumer frees the oldest full slot. The table shows which slots hold data. It also marks the slot that will receive the frame's final block, and it raises a done flag once every block of the frame has landed.

Top module: `rdc_request_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it is released, req_valid, slot_full, slot_last and frame_done are all zero.
- R2: A start pulse loads the address and the remaining length, empties the slot table and resets all three pointers to slot 0. When data remains, the first request appears on the clock edge after the edge that samples the start.
- R3: Every request length equals min(remaining blocks, max_payload, unallocated slots).
- R4: Once a request is issued, the next one comes no sooner than interval+1 cycles later. It comes exactly interval+1 cycles later when data remains and a slot is unallocated.
- R5: Each request address equals the previous request address plus the previous length times BLK_BYTES. The first request of a frame uses src_addr.
- R6: No request is issued when the computed length is zero, whether because no slot is unallocated or because no data remains. Pacing resumes as soon as a slot is freed.
- R7: Each data beat sets the slot_full bit of the landing slot, which is bit index = landing pointer, and the pointer wraps modulo NSLOT. A beat that arrives with no block outstanding is ignored.
- R8: A consume pulse clears slot_full for the oldest full slot and returns that slot to the free pool. A consume pulse is ignored when the oldest slot is not full.
- R9: In the same cycle as the frame's final request, slot_last becomes one-hot at bit (allocation pointer + length - 1) mod NSLOT. Otherwise it stays zero after a start.
- R10: frame_done rises on the edge on which the frame's last block lands. For a zero-length frame it is high right after the start edge. It stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that launches a frame |
| src_addr | input | ADDR_W | Byte address of the frame's first block |
| src_len | input | LEN_W | Frame length in blocks |
| interval | input | INTV_W | Idle cycles held between requests |
| max_payload | input | PAY_W | Largest request, in blocks |
| beat_valid | input | 1 | One block returned by the bus |
| slot_consume | input | 1 | Downstream frees the oldest full slot |
| req_valid | output | 1 | Request strobe, one cycle |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | LEN_W | Request length in blocks |
| slot_full | output | NSLOT | Per-slot data-present flags |
| slot_last | output | NSLOT | One-hot marker of the slot holding the final block |
| frame_done | output | 1 | All blocks of the frame have landed |

## Verification
The request outputs are registered. A request is therefore seen one edge after the cycle whose state allowed it: one edge after the start is sampled, one edge after a consume frees a slot, and interval+1 edges after the previous request. slot_full, slot_last and frame_done change on the same edge as the beat, consume or request that causes them. The bench drives inputs on the falling edge and samples 1 ns after the rising edge. It counts edges between request strobes and compares each count with the cycle distance due.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
   // true when v is a positive power of two
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rdc_pacer.sv
module rdc_pacer #(
   parameter int INTV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fire,
   input  logic [INTV_W-1:0] interval,
   output logic              ready
);
   logic [INTV_W-1:0] timer_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)          timer_q <= '0;
      else if (fire)              timer_q <= interval;
      else if (timer_q != '0)     timer_q <= timer_q - 1'b1;
   end

   assign ready = (timer_q == '0);
endmodule

// File: rtl/rdc_sizer.sv
module rdc_sizer #(
   parameter int LEN_W = 16,
   parameter int PAY_W = 8,
   parameter int CNT_W = 4
) (
   input  logic [LEN_W-1:0] remaining,
   input  logic [PAY_W-1:0] max_payload,
   input  logic [CNT_W-1:0] free_cnt,
   output logic [LEN_W-1:0] grant
);
   logic [LEN_W-1:0] pay_ext, free_ext, m01;

   assign pay_ext  = LEN_W'(max_payload);
   assign free_ext = LEN_W'(free_cnt);
   assign m01      = (remaining < pay_ext) ? remaining : pay_ext;
   assign grant    = (m01 < free_ext) ? m01 : free_ext;
endmodule

// File: rtl/rdc_slot_table.sv
module rdc_slot_table #(
   parameter int NSLOT = 8,
   localparam int PTR_W = $clog2(NSLOT),
   localparam int CNT_W = $clog2(NSLOT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             alloc_en,
   input  logic [CNT_W-1:0] alloc_len,
   input  logic             alloc_final,
   input  logic             beat,
   input  logic             consume,
   output logic [CNT_W-1:0] free_cnt,
   output logic             beat_ok,
   output logic [NSLOT-1:0] full,
   output logic [NSLOT-1:0] last
);
   logic [PTR_W-1:0] tail_q, head_q, drain_q, last_idx;
   logic [CNT_W-1:0] alloc_q, pend_q, add_n;
   logic             cons_ok;

   assign add_n    = alloc_en ? alloc_len : '0;
   assign beat_ok  = beat && (pend_q != '0);
   assign cons_ok  = consume && full[drain_q];
   assign free_cnt = CNT_W'(NSLOT) - alloc_q;
   assign last_idx = tail_q + alloc_len[PTR_W-1:0] - PTR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         tail_q  <= '0;
         head_q  <= '0;
         drain_q <= '0;
         alloc_q <= '0;
         pend_q  <= '0;
      end else begin
         if (alloc_en) tail_q  <= tail_q + alloc_len[PTR_W-1:0];
         if (beat_ok)  head_q  <= head_q + 1'b1;
         if (cons_ok)  drain_q <= drain_q + 1'b1;
         alloc_q <= alloc_q + add_n - (cons_ok ? CNT_W'(1) : '0);
         pend_q  <= pend_q + add_n - (beat_ok ? CNT_W'(1) : '0);
      end
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            full[i] <= 1'b0;
            last[i] <= 1'b0;
         end else begin
            if (beat_ok && head_q == PTR_W'(i))        full[i] <= 1'b1;
            else if (cons_ok && drain_q == PTR_W'(i))  full[i] <= 1'b0;
            if (alloc_en && alloc_final)               last[i] <= (last_idx == PTR_W'(i));
         end
      end
   end
endmodule

// File: rtl/rdc_request_ctrl.sv
module rdc_request_ctrl #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int PAY_W     = 8,
   parameter int INTV_W    = 8,
   parameter int NSLOT     = 8,
   parameter int BLK_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [LEN_W-1:0]  src_len,
   input  logic [INTV_W-1:0] interval,
   input  logic [PAY_W-1:0]  max_payload,
   input  logic              beat_valid,
   input  logic              slot_consume,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LEN_W-1:0]  req_len,
   output logic [NSLOT-1:0]  slot_full,
   output logic [NSLOT-1:0]  slot_last,
   output logic              frame_done
);
   import rdc_pkg::*;
   localparam int CNT_W = $clog2(NSLOT + 1);

   if (!is_pow2(NSLOT) || NSLOT < 2) begin : g_bad_nslot
      $error("NSLOT must be a power of two of at least 2");
   end
   if (LEN_W <= CNT_W || PAY_W > LEN_W) begin : g_bad_len
      $error("LEN_W must exceed the slot count width and cover PAY_W");
   end

   logic              busy_q, active_q, ready, fire, final_blk, beat_ok;
   logic [LEN_W-1:0]  rem_q, total_q, landed_q, grant;
   logic [ADDR_W-1:0] addr_q, step;
   logic [CNT_W-1:0]  free_cnt;

   rdc_pacer #(.INTV_W(INTV_W)) u_pacer (
      .clk(clk), .rst_n(rst_n), .clr(frame_start), .fire(fire),
      .interval(interval), .ready(ready));

   rdc_sizer #(.LEN_W(LEN_W), .PAY_W(PAY_W), .CNT_W(CNT_W)) u_sizer (
      .remaining(rem_q), .max_payload(max_payload), .free_cnt(free_cnt), .grant(grant));

   rdc_slot_table #(.NSLOT(NSLOT)) u_table (
      .clk(clk), .rst_n(rst_n), .clr(frame_start),
      .alloc_en(fire), .alloc_len(grant[CNT_W-1:0]), .alloc_final(final_blk),
      .beat(beat_valid), .consume(slot_consume),
      .free_cnt(free_cnt), .beat_ok(beat_ok), .full(slot_full), .last(slot_last));

   // byte step of one request: shifter when the block size allows it
   if (is_pow2(BLK_BYTES)) begin : g_step_shift
      assign step = ADDR_W'(grant) << $clog2(BLK_BYTES);
   end else begin : g_step_mul
      assign step = ADDR_W'(grant) * ADDR_W'(BLK_BYTES);
   end

   assign fire      = busy_q && !frame_start && ready && (grant != '0);
   assign final_blk = (grant == rem_q);
   assign frame_done = active_q && !busy_q && (landed_q == total_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         active_q  <= 1'b0;
         rem_q     <= '0;
         total_q   <= '0;
         landed_q  <= '0;
         addr_q    <= '0;
         req_valid <= 1'b0;
         req_addr  <= '0;
         req_len   <= '0;
      end else if (frame_start) begin
         busy_q    <= (src_len != '0);
         active_q  <= 1'b1;
         rem_q     <= src_len;
         total_q   <= src_len;
         landed_q  <= '0;
         addr_q    <= src_addr;
         req_valid <= 1'b0;
      end else begin
         req_valid <= fire;
         if (beat_ok) landed_q <= landed_q + 1'b1;
         if (fire) begin
            req_addr <= addr_q;
            req_len  <= grant;
            addr_q   <= addr_q + step;
            rem_q    <= rem_q - grant;
            if (final_blk) busy_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rdc_request_ctrl_chk.sv
module rdc_request_ctrl_chk #(
   parameter int LEN_W  = 16,
   parameter int PAY_W  = 8,
   parameter int INTV_W = 8,
   parameter int NSLOT  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic [INTV_W-1:0] interval,
   input logic [PAY_W-1:0]  max_payload,
   input logic              beat_valid,
   input logic              slot_consume,
   input logic              req_valid,
   input logic [LEN_W-1:0]  req_len,
   input logic [NSLOT-1:0]  slot_full,
   input logic [NSLOT-1:0]  slot_last,
   input logic              frame_done
);
   logic [INTV_W:0] gap_q;
   logic            seen_q;

   // idle cycles since the last request strobe, saturating
   always_ff @(posedge clk) begin
      if (!rst_n || frame_start) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (req_valid) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != '1) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   a_r6_no_empty_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_len != '0);
   a_r3_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len <= LEN_W'(max_payload)) && (req_len <= LEN_W'(NSLOT)));
   a_r4_pacing: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && seen_q) |-> gap_q >= {1'b0, interval});
   a_r9_last_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_last));
   a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !req_valid);
   a_r8_consume_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_full == '0 && slot_consume && !beat_valid && !frame_start) |=> slot_full == '0);
   a_r7_fill_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !slot_consume && !frame_start) |=>
         $countones(slot_full) >= $countones($past(slot_full)));
endmodule

bind rdc_request_ctrl rdc_request_ctrl_chk #(
   .LEN_W(LEN_W), .PAY_W(PAY_W), .INTV_W(INTV_W), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/rdc_request_ctrl_tb_top.sv
module rdc_request_ctrl_tb_top;
   localparam int ADDR_W = 32, LEN_W = 16, PAY_W = 8, INTV_W = 8, NSLOT = 8, BLK = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic frame_start = 1'b0, beat_valid = 1'b0, slot_consume = 1'b0;
   logic [ADDR_W-1:0] src_addr = '0;
   logic [LEN_W-1:0]  src_len = '0;
   logic [INTV_W-1:0] interval = '0;
   logic [PAY_W-1:0]  max_payload = '0;
   logic              req_valid, frame_done;
   logic [ADDR_W-1:0] req_addr;
   logic [LEN_W-1:0]  req_len;
   logic [NSLOT-1:0]  slot_full, slot_last;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   rdc_request_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAY_W(PAY_W), .INTV_W(INTV_W),
                      .NSLOT(NSLOT), .BLK_BYTES(BLK)) dut_i (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic start(input logic [31:0] a, input int len, input int iv, input int pay);
      @(negedge clk);
      frame_start = 1'b1; src_addr = a; src_len = LEN_W'(len);
      interval = INTV_W'(iv); max_payload = PAY_W'(pay);
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   // edges waited until req_valid is seen; -1 when none within 60
   task automatic wait_req(output int waited);
      bit found = 1'b0;
      waited = -1;
      for (int k = 1; k <= 60 && !found; k++) begin
         @(posedge clk); #1;
         if (req_valid) begin waited = k; found = 1'b1; end
      end
   endtask

   task automatic quiet(input string tag, input int n);
      int hits = 0;
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         if (req_valid) hits++;
      end
      chk(tag, hits, 0);
   endtask

   task automatic pulse_beat(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); beat_valid = 1'b1;
         @(negedge clk); beat_valid = 1'b0;
      end
   endtask

   task automatic pulse_consume();
      @(negedge clk); slot_consume = 1'b1;
      @(negedge clk); slot_consume = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 req_valid in reset", req_valid, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 req_valid", req_valid, 0);
      chk("R1 slot_full", slot_full, 0);
      chk("R1 slot_last", slot_last, 0);
      chk("R1 frame_done", frame_done, 0);
   endtask

   // 10 blocks, cap 3, interval 2: lengths 3,3,2 then slot stall
   task automatic t_paced_frame();
      int w;
      start(32'h1000_0000, 10, 2, 3);
      wait_req(w);
      chk("R2 first request latency", w, 1);
      chk("R5 first address", req_addr, 32'h1000_0000);
      chk("R3 len payload-limited", req_len, 3);
      wait_req(w);
      chk("R4 gap interval+1", w, 3);
      chk("R5 second address", req_addr, 32'h1000_0000 + 3 * BLK);
      wait_req(w);
      chk("R4 third gap", w, 3);
      chk("R3 len slot-limited", req_len, 2);
      chk("R5 third address", req_addr, 32'h1000_0000 + 6 * BLK);
      quiet("R6 stall with no free slot", 20);
      pulse_beat(8);
      chk("R7 all slots full after wrap", slot_full, 8'hFF);
      chk("R6 still stalled when full", req_valid, 0);
      pulse_consume();
      chk("R8 oldest slot freed", slot_full, 8'hFE);
      wait_req(w);
      chk("R6 resume after free", w, 1);
      chk("R3 len one free slot", req_len, 1);
      chk("R5 fourth address", req_addr, 32'h1000_0000 + 8 * BLK);
      chk("R9 no last before final", slot_last, 0);
      pulse_consume();
      wait_req(w);
      chk("R3 final len", req_len, 1);
      chk("R5 final address", req_addr, 32'h1000_0000 + 9 * BLK);
      chk("R9 last slot index 1", slot_last, 8'h02);
      chk("R10 not done before landing", frame_done, 0);
      pulse_beat(1);
      chk("R10 not done one short", frame_done, 0);
      pulse_beat(1);
      chk("R7 refilled slots", slot_full, 8'hFF);
      chk("R10 done after last block", frame_done, 1);
      quiet("R10 no request after done", 8);
   endtask

   task automatic t_zero_frame();
      start(32'h2000_0000, 0, 1, 4);
      chk("R10 zero-length frame done", frame_done, 1);
      chk("R2 start clears table", slot_full, 0);
      chk("R9 start clears last", slot_last, 0);
      quiet("R6 no request without data", 10);
      pulse_beat(1);
      chk("R7 stray beat ignored", slot_full, 0);
      pulse_consume();
      chk("R8 consume on empty ignored", slot_full, 0);
   endtask

   // remaining-limited single request, then back-to-back with interval 0
   task automatic t_short_frames();
      int w;
      start(32'h3000_0040, 2, 0, 5);
      chk("R10 done low at start", frame_done, 0);
      wait_req(w);
      chk("R3 len remaining-limited", req_len, 2);
      chk("R5 address from src_addr", req_addr, 32'h3000_0040);
      chk("R9 last slot index 1 short", slot_last, 8'h02);
      quiet("R6 nothing left to request", 6);
      pulse_beat(2);
      chk("R10 short frame done", frame_done, 1);
      start(32'h4000_0000, 3, 0, 1);
      wait_req(w);
      chk("R3 len capped at 1", req_len, 1);
      wait_req(w);
      chk("R4 interval 0 back-to-back", w, 1);
      chk("R5 step one block", req_addr, 32'h4000_0000 + BLK);
      wait_req(w);
      chk("R4 third back-to-back", w, 1);
      chk("R9 last slot index 2", slot_last, 8'h04);
   endtask

   initial begin
      t_reset();
      t_paced_frame();
      t_zero_frame();
      t_short_frames();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule